// File: doc/BRIEF.md
# CAN Bit-Timing Resynchronization Unit

This block slices every CAN bit into time quanta and keeps its local bit clock aligned with the bus. Each bit has four parts. A sync segment is always one quantum. Then come a propagation segment and phase segment 1, which together run up to the sample point. Phase segment 2 finishes the bit. The counter advances only on cycles where the time-quantum enable `tq_tick` is high. The single sample point sits on the last quantum of phase segment 1.

The receive line first passes through a two-flop synchronizer. Its level is then compared from one tick to the next to find dominant-going edges (1 to 0). An edge counts only when the last sampled bit was recessive, and only one such edge may be used per bit. While the bus is idle, a qualifying edge triggers a hard synchronization. During a frame it triggers a resynchronization instead. How large the phase error is sets the response: the bit restarts, phase segment 1 grows by the jump width, or phase segment 2 shrinks by the jump width. A node that is transmitting ignores edges that arrive late. The outputs feed a frame decoder: a sample strobe, the sampled bit value and a bit-start strobe.

Top module: `can_bit_resync`

## Requirements
- R1: While reset is held and just after it, both strobes are low and `sample_bit` reads 1 (recessive).
- R2: With no edges, a bit lasts 1+prop+ph1+ph2 ticks. `bit_start` pulses for one clock after the tick of the sync quantum. `sample_strobe` pulses for one clock after the tick of the last quantum of phase segment 1, and `sample_bit` then takes the synchronized level seen at that tick and holds it until the next sample.
- R3: The level `rx_in` reaches the edge detector two clocks late. A falling edge is a tick whose synchronized level is 0 where the previous tick's level was 1. Rising edges never change timing.
- R4: When `bus_idle` is 1, a qualifying falling edge turns the quantum in which it is seen into the sync quantum, so `bit_start` pulses and the sample follows prop+ph1 ticks later.
- R5: An edge qualifies only if the most recent sampled bit is 1, so that it differs from the dominant level after the edge.
- R6: Only one edge may be used between two natural sync quanta. After a hard sync or a restart, no other edge is used until the next natural sync quantum.
- R7: An edge seen at index k (from 0) of the prop+ph1 region has positive error k+1. If that error is at most the jump width and `tx_active` is 0, the bit restarts at that quantum.
- R8: A positive error larger than the jump width delays the sample point of the current bit by exactly the jump width.
- R9: An edge in phase segment 2 with r quanta left, counting the current one, restarts the bit there if r is at most the jump width. Otherwise phase segment 2 is shortened by exactly the jump width.
- R10: When `tx_active` is 1 and the bus is not idle, an edge before the sample point changes no timing and does not use up the bit's single synchronization.
- R11: A lengthened or shortened segment applies to the current bit only. The next bit uses the configured lengths again.
- R12: The jump width may be any value from 1 to 4. An edge seen in the sync quantum leaves the timing unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tq_tick | input | 1 | Time-quantum enable, one clock wide |
| rx_in | input | 1 | Bus receive level, 1 = recessive |
| bus_idle | input | 1 | 1 while the bus is idle (selects hard sync) |
| tx_active | input | 1 | 1 while this node transmits |
| prop_len | input | 4 | Propagation segment, 1 to 8 quanta |
| ph1_len | input | 4 | Phase segment 1, 1 to 8 quanta |
| ph2_len | input | 4 | Phase segment 2, 2 to 8 quanta |
| sjw_len | input | 3 | Jump width, 1 to 4 quanta |
| sample_strobe | output | 1 | One-clock pulse at the sample point |
| sample_bit | output | 1 | Last sampled bus value |
| bit_start | output | 1 | One-clock pulse at each sync quantum |

## Verification
An edge can be detected on the very tick that is also the last quantum of phase segment 1, where a sample is due. It can also land on the final quantum of phase segment 2, where the bit would wrap on its own. In the first case a small error restarts the bit and the sample is dropped, while a large error moves the sample out by the jump width. In the second case the restart and the natural wrap produce the same single `bit_start`. These coincidences come from pseudo-random receive waveforms whose toggle spacing sweeps around the bit length, run for every jump width and for several segment sets. A behavioural model in the bench predicts both strobes and the sample value, and they are compared on every clock.

// File: rtl/can_bt_pkg.sv
// Shared types for the CAN bit-timing resynchronization unit.
package can_bt_pkg;

    // Position of the current quantum inside the bit.
    typedef enum logic [1:0] {
        SEG_SYNC = 2'd0,
        SEG_TS1  = 2'd1,   // propagation plus phase segment 1
        SEG_PH2  = 2'd2
    } seg_e;

    // Timing correction requested for the quantum being processed.
    typedef enum logic [1:0] {
        ACT_NONE    = 2'd0,
        ACT_RESTART = 2'd1,
        ACT_EXTEND  = 2'd2,
        ACT_SHORTEN = 2'd3
    } act_e;

endpackage

// File: rtl/can_rx_sync.sv
// Receive-line conditioning.
// Brings rx_in into the clock domain through a flop chain that resets to
// recessive, then flags a falling edge on a tick whose level is 0 while the
// level seen at the previous tick was 1.
// Assumes STAGES >= 2 and a tq_tick that is one clock wide.
module can_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_in,
    input  logic tq_tick,
    output logic rx_lvl,
    output logic fall_edge
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // Metastability chain, shifting in the raw line every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], rx_in};
    end

    assign rx_lvl = chain_q[STAGES-1];

    // Remember the level seen at the last quantum tick.
    always_ff @(posedge clk) begin
        if (!rst_n)       prev_q <= 1'b1;
        else if (tq_tick) prev_q <= rx_lvl;
    end

    assign fall_edge = tq_tick && prev_q && !rx_lvl;

    // R3: after an edge, the remembered level is dominant.
    assert_edge_updates_prev_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fall_edge |=> !prev_q);

endmodule

// File: rtl/can_sync_ctrl.sv
// Synchronization decision logic.
// Qualifies falling edges (recessive last sample, one use per bit) and picks
// a hard sync, a restart, a lengthening of the sample region or a shortening
// of phase segment 2, following the phase-error rules.
// Assumes seg/cnt/ph2_eff come from registers of the bit counter.
module can_sync_ctrl
    import can_bt_pkg::*;
#(
    parameter int CNT_W = 6,
    parameter int SJW_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tq_tick,
    input  logic             fall_edge,
    input  logic             bus_idle,
    input  logic             tx_active,
    input  logic             last_sample,
    input  seg_e             seg,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] ph2_eff,
    input  logic [SJW_W-1:0] sjw_len,
    output act_e             act
);

    logic             used_q;
    logic             used_now;
    logic             qual;
    logic             taken;
    logic [CNT_W-1:0] sjw_x;
    logic [CNT_W-1:0] pos_err;
    logic [CNT_W-1:0] neg_mag;

    assign sjw_x    = CNT_W'(sjw_len);
    assign used_now = (seg == SEG_SYNC) ? 1'b0 : used_q;
    assign qual     = fall_edge && last_sample && !used_now;
    assign pos_err  = cnt + CNT_W'(1);
    assign neg_mag  = ph2_eff - cnt;

    // Select the correction for this quantum from the phase error.
    always_comb begin
        act   = ACT_NONE;
        taken = 1'b0;
        if (qual) begin
            if (bus_idle) begin
                act   = ACT_RESTART;
                taken = 1'b1;
            end else begin
                unique case (seg)
                    SEG_SYNC: taken = 1'b1;
                    SEG_TS1: begin
                        if (!tx_active) begin
                            taken = 1'b1;
                            act   = (pos_err <= sjw_x) ? ACT_RESTART : ACT_EXTEND;
                        end
                    end
                    SEG_PH2: begin
                        taken = 1'b1;
                        act   = (neg_mag <= sjw_x) ? ACT_RESTART : ACT_SHORTEN;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Track whether this bit has already used its synchronization.
    always_ff @(posedge clk) begin
        if (!rst_n)       used_q <= 1'b0;
        else if (tq_tick) used_q <= taken ? 1'b1 : used_now;
    end

    // R10: a transmitting node makes no correction before the sample point.
    assert_tx_no_pos_resync_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_active && !bus_idle && seg == SEG_TS1) |-> (act == ACT_NONE));

    // R6: a second correction in the same bit is never issued.
    assert_one_sync_per_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (act != ACT_NONE && seg != SEG_SYNC) |-> !used_q);

endmodule

// File: rtl/can_bit_counter.sv
// Quantum counter for one CAN bit.
// Steps sync -> prop+ph1 -> ph2 on each tick, applies the correction chosen by
// the controller, samples on the last quantum of the prop+ph1 region and
// emits registered one-clock strobes.
// Assumes lengths are stable outside reset and within their legal ranges.
module can_bit_counter
    import can_bt_pkg::*;
#(
    parameter int LEN_W = 4,
    parameter int SJW_W = 3,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tq_tick,
    input  logic             rx_lvl,
    input  act_e             act,
    input  logic [LEN_W-1:0] prop_len,
    input  logic [LEN_W-1:0] ph1_len,
    input  logic [LEN_W-1:0] ph2_len,
    input  logic [SJW_W-1:0] sjw_len,
    output seg_e             seg,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] ph2_eff,
    output logic             sample_strobe,
    output logic             sample_bit,
    output logic             bit_start
);

    seg_e             seg_q, seg_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] ts1_q, ts1_d, ts1_x;
    logic [CNT_W-1:0] ph2_q, ph2_d, ph2_x;
    logic             smp_stb_d, smp_bit_d, bs_d;
    logic             smp_stb_q, smp_bit_q, bs_q;
    logic [CNT_W-1:0] sjw_x;
    logic [CNT_W-1:0] ts1_nom;

    assign sjw_x   = CNT_W'(sjw_len);
    assign ts1_nom = CNT_W'(prop_len) + CNT_W'(ph1_len);
    assign ts1_x   = ts1_q + ((act == ACT_EXTEND)  ? sjw_x : '0);
    assign ph2_x   = ph2_q - ((act == ACT_SHORTEN) ? sjw_x : '0);

    // Next-state of segment position, effective lengths and strobes.
    always_comb begin
        seg_d     = seg_q;
        cnt_d     = cnt_q;
        ts1_d     = ts1_q;
        ph2_d     = ph2_q;
        smp_stb_d = 1'b0;
        smp_bit_d = smp_bit_q;
        bs_d      = 1'b0;
        if (tq_tick) begin
            if (act == ACT_RESTART || seg_q == SEG_SYNC) begin
                bs_d  = 1'b1;
                seg_d = SEG_TS1;
                cnt_d = '0;
                ts1_d = ts1_nom;
                ph2_d = CNT_W'(ph2_len);
            end else if (seg_q == SEG_TS1) begin
                ts1_d = ts1_x;
                if (cnt_q == ts1_x - CNT_W'(1)) begin
                    smp_stb_d = 1'b1;
                    smp_bit_d = rx_lvl;
                    seg_d     = SEG_PH2;
                    cnt_d     = '0;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end else begin
                ph2_d = ph2_x;
                if (cnt_q == ph2_x - CNT_W'(1)) begin
                    seg_d = SEG_SYNC;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
        end
    end

    // State and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_q     <= SEG_SYNC;
            cnt_q     <= '0;
            ts1_q     <= '0;
            ph2_q     <= '0;
            smp_stb_q <= 1'b0;
            smp_bit_q <= 1'b1;
            bs_q      <= 1'b0;
        end else begin
            seg_q     <= seg_d;
            cnt_q     <= cnt_d;
            ts1_q     <= ts1_d;
            ph2_q     <= ph2_d;
            smp_stb_q <= smp_stb_d;
            smp_bit_q <= smp_bit_d;
            bs_q      <= bs_d;
        end
    end

    assign seg           = seg_q;
    assign cnt           = cnt_q;
    assign ph2_eff       = ph2_q;
    assign sample_strobe = smp_stb_q;
    assign sample_bit    = smp_bit_q;
    assign bit_start     = bs_q;

    // R8: the sample region never grows past the nominal length plus one jump.
    assert_ext_capped_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_q == SEG_TS1) |-> (ts1_q <= ts1_nom + sjw_x && cnt_q < ts1_q));

    // R9: a shortened phase segment 2 still holds the current quantum.
    assert_ph2_floor_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_q == SEG_PH2) |-> (ph2_q >= CNT_W'(1) && cnt_q < ph2_q));

endmodule

// File: rtl/can_bit_resync.sv
// CAN bit-timing resynchronization unit, top level.
// Joins the receive conditioner, the synchronization controller and the
// bit counter. Outputs: a sample strobe with the sampled value, and a
// bit-start strobe. Assumes tq_tick comes from an external prescaler and
// that configuration changes only under reset.
module can_bit_resync
    import can_bt_pkg::*;
#(
    parameter int LEN_W       = 4,
    parameter int SJW_W       = 3,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = LEN_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tq_tick,
    input  logic             rx_in,
    input  logic             bus_idle,
    input  logic             tx_active,
    input  logic [LEN_W-1:0] prop_len,
    input  logic [LEN_W-1:0] ph1_len,
    input  logic [LEN_W-1:0] ph2_len,
    input  logic [SJW_W-1:0] sjw_len,
    output logic             sample_strobe,
    output logic             sample_bit,
    output logic             bit_start
);

    logic             rx_lvl;
    logic             fall_edge;
    act_e             act;
    seg_e             seg;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] ph2_eff;

    can_rx_sync #(.STAGES(SYNC_STAGES)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_in     (rx_in),
        .tq_tick   (tq_tick),
        .rx_lvl    (rx_lvl),
        .fall_edge (fall_edge)
    );

    can_sync_ctrl #(.CNT_W(CNT_W), .SJW_W(SJW_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .tq_tick     (tq_tick),
        .fall_edge   (fall_edge),
        .bus_idle    (bus_idle),
        .tx_active   (tx_active),
        .last_sample (sample_bit),
        .seg         (seg),
        .cnt         (cnt),
        .ph2_eff     (ph2_eff),
        .sjw_len     (sjw_len),
        .act         (act)
    );

    can_bit_counter #(.LEN_W(LEN_W), .SJW_W(SJW_W), .CNT_W(CNT_W)) u_cnt (
        .clk           (clk),
        .rst_n         (rst_n),
        .tq_tick       (tq_tick),
        .rx_lvl        (rx_lvl),
        .act           (act),
        .prop_len      (prop_len),
        .ph1_len       (ph1_len),
        .ph2_len       (ph2_len),
        .sjw_len       (sjw_len),
        .seg           (seg),
        .cnt           (cnt),
        .ph2_eff       (ph2_eff),
        .sample_strobe (sample_strobe),
        .sample_bit    (sample_bit),
        .bit_start     (bit_start)
    );

    // R2: the sample and the bit start never share a clock.
    assert_strobes_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_strobe && bit_start));

    // R2: each strobe follows a quantum tick by one clock.
    assert_strobe_after_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_strobe || bit_start) |-> $past(tq_tick));

    // R2: the sampled value changes only together with a sample strobe.
    assert_sample_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_strobe |-> $stable(sample_bit));

endmodule

// File: tb/can_bit_resync_tb_top.sv
module can_bit_resync_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tq_tick = 1'b0;
    logic       rx_in = 1'b1;
    logic       bus_idle = 1'b0;
    logic       tx_active = 1'b0;
    logic [3:0] prop_len = 4'd2;
    logic [3:0] ph1_len = 4'd3;
    logic [3:0] ph2_len = 4'd3;
    logic [2:0] sjw_len = 3'd2;
    logic       sample_strobe, sample_bit, bit_start;

    int checks = 0;
    int errors = 0;
    int tick_div = 2;
    int div_cnt = 0;
    int cyc = 0;
    bit chk_en = 0;
    bit done = 0;
    string cur_req = "R1";
    int unsigned seed = 32'h1234_5678;

    always #4 clk = ~clk;

    can_bit_resync dut_i (
        .clk(clk), .rst_n(rst_n), .tq_tick(tq_tick), .rx_in(rx_in),
        .bus_idle(bus_idle), .tx_active(tx_active), .prop_len(prop_len),
        .ph1_len(ph1_len), .ph2_len(ph2_len), .sjw_len(sjw_len),
        .sample_strobe(sample_strobe), .sample_bit(sample_bit), .bit_start(bit_start)
    );

    // Quantum tick generator, driven away from the active edge.
    always @(negedge clk) begin
        tq_tick = (div_cnt == 0);
        div_cnt = (div_cnt + 1 >= tick_div) ? 0 : div_cnt + 1;
    end

    always @(posedge clk) cyc <= cyc + 1;

    // Behavioural reference model of the whole unit.
    int  m_a, m_b, m_prev, m_ph, m_cnt, m_s1, m_s2, m_used, m_last, m_act;
    bit  e_ss, e_bs;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_a = 1; m_b = 1; m_prev = 1; m_ph = 0; m_cnt = 0;
            m_used = 0; m_last = 1; e_ss = 0; e_bs = 0; m_s1 = 0; m_s2 = 0;
        end else begin
            e_ss = 0; e_bs = 0;
            if (tq_tick) begin
                int lvl;
                lvl = m_b;
                m_act = 0;
                if (m_ph == 0) m_used = 0;
                if (m_prev == 1 && lvl == 0 && m_last == 1 && m_used == 0) begin
                    if (bus_idle) begin m_act = 1; m_used = 1; end
                    else if (m_ph == 0) m_used = 1;
                    else if (m_ph == 1) begin
                        if (!tx_active) begin
                            m_used = 1;
                            m_act = (m_cnt + 1 <= int'(sjw_len)) ? 1 : 2;
                        end
                    end else begin
                        m_used = 1;
                        m_act = (m_s2 - m_cnt <= int'(sjw_len)) ? 1 : 3;
                    end
                end
                m_prev = lvl;
                if (m_act == 1 || m_ph == 0) begin
                    e_bs = 1; m_ph = 1; m_cnt = 0;
                    m_s1 = int'(prop_len) + int'(ph1_len); m_s2 = int'(ph2_len);
                end else if (m_ph == 1) begin
                    if (m_act == 2) m_s1 = m_s1 + int'(sjw_len);
                    if (m_cnt == m_s1 - 1) begin
                        e_ss = 1; m_last = lvl; m_ph = 2; m_cnt = 0;
                    end else m_cnt++;
                end else begin
                    if (m_act == 3) m_s2 = m_s2 - int'(sjw_len);
                    if (m_cnt == m_s2 - 1) begin m_ph = 0; m_cnt = 0; end
                    else m_cnt++;
                end
            end
            m_b = m_a; m_a = int'(rx_in);
        end
    end

    // Compare the design with the model on every clock.
    always @(negedge clk) begin
        if (chk_en && !done) begin
            checks++;
            if (sample_strobe !== e_ss || bit_start !== e_bs || sample_bit !== m_last[0]) begin
                errors++;
                $display("FAIL %s cyc %0d: ss/bs/bit got %b%b%b expected %b%b%b",
                         cur_req, cyc, sample_strobe, bit_start, sample_bit,
                         e_ss, e_bs, m_last[0]);
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act_v, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act_v, exp_v);
        end
    endtask

    task automatic apply_reset(input int p, input int a, input int b, input int s, input int div);
        @(negedge clk);
        rst_n = 0; rx_in = 1;
        prop_len = 4'(p); ph1_len = 4'(a); ph2_len = 4'(b); sjw_len = 3'(s);
        tick_div = div;
        repeat (4) @(negedge clk);
        cur_req = "R1";
        check(sample_strobe == 0 && bit_start == 0, "R1 strobes low in reset",
              int'(sample_strobe) + int'(bit_start), 0);
        check(sample_bit == 1, "R1 sample_bit recessive in reset", int'(sample_bit), 1);
        rst_n = 1;
        chk_en = 1;
    endtask

    // Pseudo-random receive waveform with toggle spacing around one bit.
    task automatic rand_rx(input int n, input int lo, input int span);
        int t = 0;
        while (t < n) begin
            int d;
            seed = seed * 32'd1103515245 + 32'd12345;
            d = lo + int'((seed >> 16) % span);
            rx_in = ~rx_in;
            repeat (d) @(negedge clk);
            t += d;
        end
        rx_in = 1;
        repeat (60) @(negedge clk);
    endtask

    task automatic wait_bs(output int at);
        int guard = 0;
        while (bit_start !== 1'b1 && guard < 400) begin @(negedge clk); guard++; end
        at = cyc;
    endtask

    initial begin
        int t0, t1, n;
        // R1 and R2: free-running nominal bit length.
        apply_reset(2, 3, 3, 2, 2);
        cur_req = "R2";
        repeat (3) @(negedge clk);
        wait_bs(t0); @(negedge clk);
        wait_bs(t1);
        check(t1 - t0 == 9 * 2, "R2 nominal bit period", t1 - t0, 18);
        @(negedge clk);
        n = 0;
        while (sample_strobe !== 1'b1 && n < 100) begin @(negedge clk); n++; end
        check(n + 1 == (2 + 3) * 2, "R2 sample point offset", n + 1, 10);

        // R4: hard sync at idle, then sample follows prop+ph1 ticks later.
        apply_reset(2, 3, 3, 2, 2);
        cur_req = "R4"; bus_idle = 1;
        repeat (5) @(negedge clk);
        wait_bs(t0); @(negedge clk);
        rx_in = 0;
        n = 0;
        while (bit_start !== 1'b1 && n < 10) begin @(negedge clk); n++; end
        check(n <= 4, "R4 bit_start soon after idle edge", n, 4);
        repeat ((2 + 3) * 2) @(negedge clk);
        check(sample_strobe == 1 && sample_bit == 0, "R4 sample after hard sync",
              int'(sample_strobe) * 2 + int'(sample_bit), 2);
        repeat (30) @(negedge clk);
        rx_in = 1;
        repeat (30) @(negedge clk);
        cur_req = "R4 R5 R3 idle random";
        rand_rx(600, 4, 30);
        bus_idle = 0;

        // R5..R9, R11, R12: every jump width, resync under random edges.
        for (int s = 1; s <= 4; s++) begin
            apply_reset(2, 3, 3, s, 2);
            cur_req = "R3 R5 R6 R7 R8 R9 R11 R12 receive";
            rand_rx(1200, 8, 28);
            apply_reset(3, 4, 4, s, 2);
            rand_rx(1200, 10, 30);
        end

        // R10: transmitting node ignores late edges.
        for (int s = 1; s <= 4; s++) begin
            apply_reset(2, 3, 3, s, 2);
            cur_req = "R10 transmit"; tx_active = 1;
            rand_rx(1200, 8, 28);
            tx_active = 0;
        end

        // R12 and R11: extreme lengths, tick every clock.
        apply_reset(1, 1, 2, 4, 1);
        cur_req = "R12 R11 short bit";
        rand_rx(1500, 2, 8);
        apply_reset(8, 8, 8, 4, 1);
        cur_req = "R11 R8 R9 long bit";
        rand_rx(2500, 10, 40);
        apply_reset(8, 8, 2, 1, 3);
        cur_req = "R9 R6 slow tick";
        rand_rx(3000, 20, 60);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule